// File: doc/BRIEF.md
# Serial EEPROM Target over a Two-Wire Bus

This block is a synthesizable two-wire (I2C) bus target that behaves like a 2 KB serial EEPROM. It oversamples the bus clock and data lines with the system clock, recognises START and STOP, and acknowledges a control byte that carries a fixed four-bit device code, a three-bit bank number and a read/write flag. A write continues with one word-address byte and then data bytes. A read returns bytes from the current pointer until the master withholds its acknowledge.

Written bytes collect in a 16-byte page buffer. When the STOP arrives they are programmed into the array over a self-timed interval that is counted in system clocks. While that interval runs, the busy output stays high and the target acknowledges nothing. A write-protect input blocks every change to the array. The data line is never driven high: the block only asserts a pull-low enable, and the pad merges it with the master's open-drain drive.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A transaction opens only on a START, which is SDA falling while SCL is high. After a STOP (SDA rising while SCL is high), bytes clocked without a new START are ignored and get no acknowledge.
- R2: The control byte is acknowledged only when its upper four bits equal DEV_CODE (default 4'b1010) and no programming interval runs. Bits 3..1 are the bank and become address bits 10..8. Bit 0 set means read.
- R3: For each accepted control, address or write-data byte, the target pulls SDA low from the SCL falling edge after the eighth bit until the falling edge of the ninth pulse. The pull-low only begins while SCL is low.
- R4: A single byte written with address byte A under bank B reads back at address {B,A}.
- R5: Write data goes to the page buffer at column address bits 3..0, and the column wraps inside its 16-byte page. With more than 16 bytes, the later bytes overwrite the earliest ones, so only the last 16 are kept.
- R6: Buffered data is programmed only when a STOP ends the write-data phase. If a repeated START comes first, the write is dropped.
- R7: After a committing STOP, busy_o is high for exactly WR_CYCLES clocks, and no byte is acknowledged in that time.
- R8: While wp_i is high at the STOP, the data bytes are still acknowledged but the array is unchanged and busy_o stays low.
- R9: A repeated START keeps the address pointer. A dummy write (control plus address byte) followed by a repeated START and a read control byte returns the byte at that address.
- R10: During a read, the pointer increments after each byte the master acknowledges, wrapping from 0x7FF to 0x000.
- R11: When the master leaves SDA high after a read byte, the target releases SDA and does not advance the pointer. A later current-address read returns that same byte.
- R12: After reset, SDA is released and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| wp_i | input | 1 | High blocks programming of the array |
| sda_low_o | output | 1 | Pull-low enable for the open-drain data pad |
| busy_o | output | 1 | High while the timed programming interval runs |

## Verification
The bench builds the block with WR_CYCLES set to 2000 and keeps the other defaults. That interval is longer than a START plus one control byte at the bench's bus rate, so a control byte sent during programming falls inside the silent window and must get no acknowledge. It is also short enough that several page and byte writes, the overflowing 20-byte page and the wrap of the pointer at the top of the array all fit in one short run.

// File: rtl/eeprom_i2c_target.sv
`timescale 1ns/1ps
module eeprom_i2c_target #(
  parameter int         PAGE_W    = 4,
  parameter int         WR_CYCLES = 400000,
  parameter logic [3:0] DEV_CODE  = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_low_o,
  output logic busy_o
);
  localparam int BANK_W = 3;
  localparam int AW     = BANK_W + 8;
  localparam int DEPTH  = 1 << AW;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int CW     = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WR, S_RD} st_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_d, sda_d, scl_q, sda_q;
  logic       start_c, stop_c, rise, fall;

  st_t              st;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [AW-1:0]    addr, nxt;
  logic             mack;
  logic [PAGE-1:0]  pvalid;
  logic [AW-PAGE_W-1:0] ppage;
  logic [CW-1:0]    pcnt;
  logic             busy, sda_low;
  logic             wr_byte, prog_we;

  logic [7:0] pbuf [PAGE];
  logic [7:0] mem  [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_d <= scl_s[1];
      sda_d <= sda_s[1];
    end
  end

  assign scl_q   = scl_s[1];
  assign sda_q   = sda_s[1];
  assign start_c = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_c  = scl_q & scl_d & ~sda_d & sda_q;
  assign rise    = scl_q & ~scl_d;
  assign fall    = ~scl_q & scl_d;
  assign nxt     = addr + 1'b1;

  assign wr_byte = fall && (st == S_WR) && (bitcnt == 4'd8);
  assign prog_we = busy && (pcnt < CW'(PAGE)) && pvalid[pcnt[PAGE_W-1:0]];

  always_ff @(posedge clk) begin
    if (wr_byte) pbuf[addr[PAGE_W-1:0]] <= shreg;
  end

  always_ff @(posedge clk) begin
    if (prog_we) mem[{ppage, pcnt[PAGE_W-1:0]}] <= pbuf[pcnt[PAGE_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      addr    <= '0;
      mack    <= 1'b0;
      pvalid  <= '0;
      ppage   <= '0;
      pcnt    <= '0;
      busy    <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      if (busy) begin
        pcnt <= pcnt + 1'b1;
        if (pcnt == CW'(WR_CYCLES - 1)) busy <= 1'b0;
      end
      if (start_c) begin
        st      <= S_CTRL;
        bitcnt  <= '0;
        sda_low <= 1'b0;
      end else if (stop_c) begin
        if (st == S_WR && |pvalid && !wp_i && !busy) begin
          busy  <= 1'b1;
          pcnt  <= '0;
          ppage <= addr[AW-1:PAGE_W];
        end
        st      <= S_IDLE;
        sda_low <= 1'b0;
      end else begin
        case (st)
          S_CTRL, S_ADDR, S_WR: begin
            if (rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_q};
              bitcnt <= bitcnt + 1'b1;
            end
            if (fall && bitcnt == 4'd8) begin
              case (st)
                S_CTRL: begin
                  if (shreg[7:4] == DEV_CODE && !busy) begin
                    sda_low         <= 1'b1;
                    bitcnt          <= 4'd9;
                    addr[AW-1:8]    <= shreg[BANK_W:1];
                    if (!shreg[0]) pvalid <= '0;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                S_ADDR: begin
                  addr[7:0] <= shreg;
                  sda_low   <= 1'b1;
                  bitcnt    <= 4'd9;
                end
                default: begin
                  pvalid[addr[PAGE_W-1:0]] <= 1'b1;
                  addr[PAGE_W-1:0]         <= addr[PAGE_W-1:0] + 1'b1;
                  sda_low                  <= 1'b1;
                  bitcnt                   <= 4'd9;
                end
              endcase
            end
            if (fall && bitcnt == 4'd9) begin
              sda_low <= 1'b0;
              bitcnt  <= '0;
              if (st == S_CTRL) begin
                if (shreg[0]) begin
                  st      <= S_RD;
                  shreg   <= mem[addr];
                  sda_low <= ~mem[addr][7];
                end else begin
                  st <= S_ADDR;
                end
              end else if (st == S_ADDR) begin
                st <= S_WR;
              end
            end
          end
          S_RD: begin
            if (rise && bitcnt < 4'd8) bitcnt <= bitcnt + 1'b1;
            if (rise && bitcnt == 4'd9) mack <= ~sda_q;
            if (fall) begin
              if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                shreg   <= {shreg[6:0], 1'b0};
                sda_low <= ~shreg[6];
              end else if (bitcnt == 4'd8) begin
                sda_low <= 1'b0;
                bitcnt  <= 4'd9;
              end else if (bitcnt == 4'd9) begin
                bitcnt <= '0;
                if (mack) begin
                  addr    <= nxt;
                  shreg   <= mem[nxt];
                  sda_low <= ~mem[nxt][7];
                end else begin
                  st <= S_IDLE;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_low_o = sda_low;
  assign busy_o    = busy;
endmodule

// File: rtl/eeprom_i2c_target_chk.sv
`timescale 1ns/1ps
module eeprom_i2c_target_chk #(
  parameter int WR_CYCLES = 400000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic wp_i,
  input logic sda_low_o,
  input logic busy_o
);
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else        run <= busy_o ? run + 1 : 0;
  end

  // R7: programming keeps the target off the bus
  a_r7_silent_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_low_o);

  // R3: the pull-low starts only in the low phase of SCL
  a_r3_drive_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_o) |-> !scl_i);

  // R7: the busy window lasts exactly WR_CYCLES clocks
  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run == 32'(WR_CYCLES));

  // R8: no programming starts while write-protect is high
  a_r8_protect_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(wp_i));
endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .scl_i(scl_i),
  .wp_i(wp_i),
  .sda_low_o(sda_low_o),
  .busy_o(busy_o)
);

// File: tb/eeprom_i2c_target_tb.sv
`timescale 1ns/1ps
module eeprom_i2c_target_tb;
  localparam int WRC = 2000;
  localparam int Q   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_low, busy, sda_line;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_low;

  eeprom_i2c_target #(.WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .wp_i(wp),
    .sda_low_o(sda_low), .busy_o(busy)
  );

  int n_checks = 0, n_fail = 0;
  int busy_run = 0, last_busy_len = 0;
  logic [7:0]  ref_mem [2048];
  logic [10:0] ptr = '0;
  logic [7:0]  exp_q [$];
  string       req_q [$];
  logic [7:0]  got_v;
  event        got;
  bit          done = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (busy) busy_run++;
    else if (busy_run != 0) begin
      last_busy_len = busy_run;
      busy_run = 0;
    end
  end

  initial begin
    forever begin
      @(got);
      if (exp_q.size() == 0) check(0, "scoreboard", got_v, 0);
      else begin
        logic [7:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(got_v === e, r, got_v, e);
      end
    end
  end

  task automatic bus_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); b = sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask
  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    got_v = v;
    -> got;
    put_bit(!give_ack);
  endtask

  task automatic write_seq(input logic [2:0] bank, input logic [7:0] a, input int n,
                           input logic [7:0] base, input bit do_stop, input string req);
    bit ack;
    logic [7:0] pv [16];
    bit pm [16];
    for (int i = 0; i < 16; i++) pm[i] = 0;
    bus_start();
    send_byte({4'b1010, bank, 1'b0}, ack); check(ack, "R2 ctrl ack", ack, 1);
    send_byte(a, ack);                     check(ack, "R3 addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [3:0] col;
      col = a[3:0] + 4'(i);
      pv[col] = base + 8'(i);
      pm[col] = 1;
      send_byte(base + 8'(i), ack);        check(ack, {req, " data ack"}, ack, 1);
    end
    ptr = {bank, a[7:4], a[3:0] + 4'(n)};
    if (do_stop) begin
      bus_stop();
      if (!wp)
        for (int i = 0; i < 16; i++)
          if (pm[i]) ref_mem[{bank, a[7:4], 4'(i)}] = pv[i];
    end
  endtask

  task automatic read_body(input logic [2:0] bank, input int n, input string req);
    bit ack;
    logic [7:0] v;
    send_byte({4'b1010, bank, 1'b1}, ack); check(ack, "R9 read ctrl ack", ack, 1);
    ptr[10:8] = bank;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(ref_mem[ptr]);
      req_q.push_back(req);
      recv_byte(i < n - 1, v);
      if (i < n - 1) ptr = ptr + 1'b1;
    end
  endtask

  task automatic read_rand(input logic [2:0] bank, input logic [7:0] a, input int n, input string req);
    bit ack;
    bus_start();
    send_byte({4'b1010, bank, 1'b0}, ack); check(ack, "R9 dummy ctrl ack", ack, 1);
    send_byte(a, ack);                     check(ack, "R9 dummy addr ack", ack, 1);
    ptr = {bank, a};
    bus_start();
    read_body(bank, n, req);
    bus_stop();
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
    tick(Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    bit ack;
    logic b;
    tick(5);
    rst_n = 1;
    tick(3);
    check(sda_low == 0, "R12 sda released", sda_low, 0);
    check(busy == 0, "R12 busy low", busy, 0);

    // R4 byte write, R7 busy and silence
    write_seq(3'd2, 8'h35, 1, 8'hA5, 1, "R3");
    check(busy == 1, "R7 busy after stop", busy, 1);
    bus_start();
    send_byte({4'b1010, 3'd2, 1'b0}, ack);
    check(!ack, "R7 no ack while busy", ack, 0);
    bus_stop();
    wait_idle();
    check(last_busy_len == WRC, "R7 busy length", last_busy_len, WRC);

    // R9 random read, R4 data
    read_rand(3'd2, 8'h35, 1, "R4 byte readback");

    // R11 nack releases, pointer kept
    bus_start();
    send_byte({4'b1010, 3'd2, 1'b1}, ack); check(ack, "R11 ctrl ack", ack, 1);
    exp_q.push_back(ref_mem[ptr]); req_q.push_back("R11 current read");
    begin logic [7:0] v; recv_byte(0, v); end
    get_bit(b);
    check(b == 1, "R11 sda released after nack", b, 1);
    bus_stop();

    // R5 page overflow, R10 sequential read
    write_seq(3'd5, 8'h40, 20, 8'h10, 1, "R5");
    wait_idle();
    read_rand(3'd5, 8'h40, 16, "R5 page overflow");
    check(ref_mem[11'h540] == 8'h20, "R5 model col0", ref_mem[11'h540], 8'h20);

    // R10 wrap
    write_seq(3'd7, 8'hFF, 1, 8'hEE, 1, "R3");
    wait_idle();
    write_seq(3'd0, 8'h00, 1, 8'h11, 1, "R3");
    wait_idle();
    read_rand(3'd7, 8'hFF, 2, "R10 wrap read");

    // R8 write protect
    wp = 1;
    write_seq(3'd2, 8'h35, 1, 8'h5A, 1, "R8");
    tick(20);
    check(busy == 0, "R8 no busy under protect", busy, 0);
    wp = 0;
    read_rand(3'd2, 8'h35, 1, "R8 array unchanged");

    // R6 repeated start aborts write
    write_seq(3'd2, 8'h35, 1, 8'h77, 0, "R6");
    bus_start();
    bus_stop();
    tick(20);
    check(busy == 0, "R6 no commit on abort", busy, 0);
    read_rand(3'd2, 8'h35, 1, "R6 array unchanged");

    // R2 wrong device code
    bus_start();
    send_byte(8'h64, ack);
    check(!ack, "R2 wrong code nack", ack, 0);
    bus_stop();

    // R1 bytes without START ignored
    send_byte({4'b1010, 3'd2, 1'b0}, ack);
    check(!ack, "R1 no start no ack", ack, 0);
    bus_stop();

    tick(Q);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule